// File: doc/BRIEF.md
# Free-Running 64-bit Counter with Atomic Snapshot and Preload

This block keeps a continuously running 64-bit count behind a 32-bit register
interface. A programmable prescaler divides the input clock so the count
advances once every N+1 cycles, where N is a 16-bit field of the control word.
The count wraps modulo 2^64 and never stops.

A 64-bit value cannot be read in one 32-bit access without the risk of a carry
landing between the two halves. Software therefore writes a snapshot command
to the control word. In that same clock the whole count is copied into a
64-bit latched pair, and the pair can then be read word by word at leisure.
A second command encoding in the same control word copies a 64-bit preload
value, held in its own pair of writable registers, into the counter and
restarts the prescale phase.

Command decode is a small enumerated decision per bus cycle: `CMD_NONE` (any
write elsewhere, or control bits [1:0] = 00 or 10), `CMD_SNAP` (bits [1:0] =
01) and `CMD_LOAD` (bits [1:0] = 11). Every command lasts exactly the cycle of
the write and falls back to `CMD_NONE` on the next cycle. The prescaler
alternates between accumulating (phase below N) and firing (phase at or above
N, one increment, phase back to zero). A load forces it back to accumulating
from zero.

Top module: `timer64_snap`

## Requirements
- R1: After reset the count, the prescale field, the preload pair and the latched pair are all zero, and the count starts advancing without any command.
- R2: With prescale field N held in control bits [31:16], the count advances by one every N+1 clocks.
- R3: A write to the control word at 0x68 with bit 0 set and bit 1 clear copies all 64 count bits into the latched pair (low at 0x7C, high at 0x80) at that clock edge; if the count advances at the same edge, the value before the advance is captured.
- R4: The latched pair keeps its value through increments, loads, reads and all other writes until the next snapshot command.
- R5: A write to the control word with bits 0 and 1 both set loads the count from the preload pair at that edge and resets the prescale phase, so the next advance follows N+1 clocks later.
- R6: Control bits 0 and 1 are one-shot strobes and always read back as zero; control values with bits [1:0] = 00 or 10 issue no command; every control write stores bits [31:16] as the new prescale value, which reads back unchanged.
- R7: The count carries across the 32-bit word boundary and wraps from all ones to zero.
- R8: The live count reads at 0x6C (low) and 0x70 (high); writes to the live and latched addresses have no effect.
- R9: The preload pair at 0x74 (low) and 0x78 (high) is written and read back as stored; unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for counter, prescaler and registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The bench builds the block with its default parameters: a 64-bit count, 32-bit
words and a 16-bit prescale field. A prescale of 0 makes every edge an
increment, so snapshot-during-increment, the low-to-high carry and the full
wrap are reached within a few cycles of a preload near the boundary. A
prescale of 3 exposes the N+1 spacing and the phase restart on load, and the
maximum prescale of 0xFFFF freezes the count long enough that snapshot and
preload values can be checked against exact constants.

// File: rtl/timer64_pkg.sv
`timescale 1ns/1ps
package timer64_pkg;

    localparam int unsigned ADDR_W = 8;

    // Register offsets; the high word of each pair sits 4 bytes above the low word.
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h68;
    localparam logic [ADDR_W-1:0] OFS_LIVE  = 8'h6C;
    localparam logic [ADDR_W-1:0] OFS_PRELD = 8'h74;
    localparam logic [ADDR_W-1:0] OFS_SNAP  = 8'h7C;

    // Control word field positions.
    localparam int unsigned SNAP_BIT  = 0;
    localparam int unsigned LOAD_BIT  = 1;
    localparam int unsigned PRESC_LSB = 16;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_SNAP = 2'd1,
        CMD_LOAD = 2'd2
    } cmd_e;

    typedef enum logic {
        PH_ACCUM = 1'b0,
        PH_FIRE  = 1'b1
    } phase_e;

endpackage

// File: rtl/timer64_prescaler.sv
`timescale 1ns/1ps
module timer64_prescaler
    import timer64_pkg::*;
#(
    parameter int unsigned PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] presc,
    input  logic               restart,
    output logic               tick
);

    logic [PRESC_W-1:0] phase_q;
    phase_e             phase_st;

    // Firing once the phase has reached the divider; >= keeps a shrinking
    // divider from waiting out a full wrap of the phase counter.
    always_comb begin
        phase_st = (phase_q >= presc) ? PH_FIRE : PH_ACCUM;
    end

    always_comb begin
        unique case (phase_st)
            PH_FIRE:  tick = 1'b1;
            PH_ACCUM: tick = 1'b0;
            default:  tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else begin
            unique case (phase_st)
                PH_FIRE:  phase_q <= '0;
                PH_ACCUM: phase_q <= phase_q + PRESC_W'(1);
                default:  phase_q <= '0;
            endcase
        end
    end

endmodule

// File: rtl/timer64_counter.sv
`timescale 1ns/1ps
module timer64_counter #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             snap_en,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] latched
);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] latched_q;
    logic [CNT_W-1:0] count_d;

    always_comb begin
        if (load_en) begin
            count_d = load_val;
        end else if (tick) begin
            count_d = count_q + CNT_W'(1);
        end else begin
            count_d = count_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    // Capture the pre-update count: all bits in one edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latched_q <= '0;
        end else if (snap_en) begin
            latched_q <= count_q;
        end
    end

    assign count   = count_q;
    assign latched = latched_q;

endmodule

// File: rtl/timer64_regs.sv
`timescale 1ns/1ps
module timer64_regs
    import timer64_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CNT_W   = 64,
    parameter int unsigned PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [CNT_W-1:0]   count,
    input  logic [CNT_W-1:0]   latched,
    output logic [PRESC_W-1:0] presc,
    output logic [CNT_W-1:0]   preload,
    output cmd_e               cmd,
    output logic [DATA_W-1:0]  rdata
);

    localparam int unsigned NWORDS = CNT_W / DATA_W;
    localparam int unsigned WSTEP  = DATA_W / 8;

    logic               ctrl_wr;
    logic [PRESC_W-1:0] presc_q;
    logic [DATA_W-1:0]  preload_q [NWORDS];

    assign ctrl_wr = wr && (addr == OFS_CTRL);

    // Command decode: one cycle per write, NONE otherwise.
    always_comb begin
        cmd = CMD_NONE;
        if (ctrl_wr) begin
            unique case ({wdata[LOAD_BIT], wdata[SNAP_BIT]})
                2'b01:   cmd = CMD_SNAP;
                2'b11:   cmd = CMD_LOAD;
                default: cmd = CMD_NONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
        end else if (ctrl_wr) begin
            presc_q <= wdata[PRESC_LSB +: PRESC_W];
        end
    end

    generate
        for (genvar gi = 0; gi < NWORDS; gi++) begin : g_preload
            localparam logic [ADDR_W-1:0] WADDR = OFS_PRELD + ADDR_W'(WSTEP * gi);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    preload_q[gi] <= '0;
                end else if (wr && (addr == WADDR)) begin
                    preload_q[gi] <= wdata;
                end
            end
            assign preload[gi*DATA_W +: DATA_W] = preload_q[gi];
        end
    endgenerate

    // Read mux; strobe bits of the control word are never stored.
    always_comb begin
        rdata = '0;
        if (addr == OFS_CTRL) begin
            rdata[PRESC_LSB +: PRESC_W] = presc_q;
        end
        for (int w = 0; w < NWORDS; w++) begin
            if (addr == OFS_LIVE + ADDR_W'(WSTEP * w)) begin
                rdata = count[w*DATA_W +: DATA_W];
            end
            if (addr == OFS_PRELD + ADDR_W'(WSTEP * w)) begin
                rdata = preload_q[w];
            end
            if (addr == OFS_SNAP + ADDR_W'(WSTEP * w)) begin
                rdata = latched[w*DATA_W +: DATA_W];
            end
        end
    end

    assign presc = presc_q;

endmodule

// File: rtl/timer64_snap.sv
`timescale 1ns/1ps
module timer64_snap
    import timer64_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned PRESC_W = 16,
    parameter int unsigned CNT_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    logic [PRESC_W-1:0] presc_w;
    logic [CNT_W-1:0]   preload_w;
    logic [CNT_W-1:0]   count_w;
    logic [CNT_W-1:0]   latched_w;
    cmd_e               cmd_w;
    logic               tick_w;
    logic               load_en;
    logic               snap_en;

    assign load_en = (cmd_w == CMD_LOAD);
    assign snap_en = (cmd_w == CMD_SNAP);

    timer64_regs #(
        .DATA_W  (DATA_W),
        .CNT_W   (CNT_W),
        .PRESC_W (PRESC_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .count   (count_w),
        .latched (latched_w),
        .presc   (presc_w),
        .preload (preload_w),
        .cmd     (cmd_w),
        .rdata   (bus_rdata)
    );

    timer64_prescaler #(
        .PRESC_W (PRESC_W)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .presc   (presc_w),
        .restart (load_en),
        .tick    (tick_w)
    );

    timer64_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_w),
        .load_en  (load_en),
        .load_val (preload_w),
        .snap_en  (snap_en),
        .count    (count_w),
        .latched  (latched_w)
    );

endmodule

// File: rtl/timer64_snap_chk.sv
`timescale 1ns/1ps
module timer64_snap_chk
    import timer64_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned PRESC_W = 16,
    parameter int unsigned CNT_W   = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [PRESC_W-1:0] presc,
    input logic [CNT_W-1:0]   preload,
    input logic [CNT_W-1:0]   count,
    input logic [CNT_W-1:0]   latched
);

    logic snap_req;
    logic load_req;

    assign snap_req = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[SNAP_BIT] && !bus_wdata[LOAD_BIT];
    assign load_req = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[SNAP_BIT] && bus_wdata[LOAD_BIT];

    AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> (latched == $past(count))) else $error("snapshot value"); // R3

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> $stable(latched)) else $error("latched moved"); // R4

    AST_LOAD_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> (count == $past(preload))) else $error("preload value"); // R5

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load_req |=> ((count == $past(count)) || (count == $past(count) + CNT_W'(1))))
        else $error("count jumped"); // R7

    AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((presc == '0) && !load_req) |=> (count == $past(count) + CNT_W'(1)))
        else $error("divider zero must step every clock"); // R2

    always_comb begin
        if (rst_n && (bus_addr == OFS_CTRL)) begin
            AST_STROBE_CLEAR: assert (bus_rdata[LOAD_BIT:SNAP_BIT] == 2'b00) else $error("strobe bits read back"); // R6
        end
    end

endmodule

bind timer64_snap timer64_snap_chk #(
    .DATA_W  (DATA_W),
    .PRESC_W (PRESC_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .presc     (presc_w),
    .preload   (preload_w),
    .count     (count_w),
    .latched   (latched_w)
);

// File: tb/tb_timer64_snap.sv
`timescale 1ns/1ps
module tb_timer64_snap;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    timer64_snap dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // Behavioural reference model.
    logic [63:0] m_count = '0;
    logic [63:0] m_load  = '0;
    logic [63:0] m_latch = '0;
    int          m_div   = 0;
    int          m_presc = 0;
    logic [63:0] m_old;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_count = '0; m_load = '0; m_latch = '0; m_div = 0; m_presc = 0;
        end else begin
            m_old = m_count;
            if (m_div >= m_presc) begin
                m_count = m_count + 64'd1;
                m_div = 0;
            end else begin
                m_div = m_div + 1;
            end
            if (bus_wr) begin
                case (bus_addr)
                    8'h68: begin
                        if (bus_wdata[1:0] == 2'b01) m_latch = m_old;
                        if (bus_wdata[1:0] == 2'b11) begin
                            m_count = m_load;
                            m_div = 0;
                        end
                        m_presc = int'(bus_wdata[31:16]);
                    end
                    8'h74: m_load[31:0]  = bus_wdata;
                    8'h78: m_load[63:32] = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h68: return {16'(m_presc), 16'h0};
            8'h6C: return m_count[31:0];
            8'h70: return m_count[63:32];
            8'h74: return m_load[31:0];
            8'h78: return m_load[63:32];
            8'h7C: return m_latch[31:0];
            8'h80: return m_latch[63:32];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_for(input logic [7:0] a);
        case (a)
            8'h68: return "R6";
            8'h6C, 8'h70: return "R8";
            8'h74, 8'h78: return "R9";
            8'h7C, 8'h80: return "R4";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(req_for(bus_addr), "per-clock read", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(posedge clk); #2;
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset state
        rd(8'h68, v); chk("R1", "ctrl after reset", v, 32'h0);
        rd(8'h74, v); chk("R1", "preload lo after reset", v, 32'h0);
        rd(8'h78, v); chk("R1", "preload hi after reset", v, 32'h0);
        rd(8'h7C, v); chk("R1", "latched lo after reset", v, 32'h0);
        rd(8'h80, v); chk("R1", "latched hi after reset", v, 32'h0);
        rd(8'h6C, v); chk("R1", "count runs after reset", 32'(v != 0), 32'h1);

        // R2 / R5: divider 3, load 100, phase restart
        wr(8'h74, 32'd100);
        wr(8'h78, 32'd0);
        wr(8'h68, 32'h0003_0003);
        @(posedge clk); #2 bus_addr = 8'h6C;
        #1 chk("R5", "count right after load", bus_rdata, 32'd100);
        @(posedge clk); @(posedge clk); #3;
        chk("R5", "no step before N+1 clocks", bus_rdata, 32'd100);
        @(posedge clk); #3;
        chk("R5", "first step N+1 after load", bus_rdata, 32'd101);
        repeat (3) @(posedge clk); #3;
        chk("R2", "held within period", bus_rdata, 32'd101);
        @(posedge clk); #3;
        chk("R2", "step after N+1 clocks", bus_rdata, 32'd102);

        // R3 / R4: frozen count, snapshot, then reload
        wr(8'h74, 32'h9ABC_DEF0);
        wr(8'h78, 32'h1234_5678);
        wr(8'h68, 32'hFFFF_0003);
        wr(8'h68, 32'hFFFF_0001);
        rd(8'h80, v); chk("R3", "snapshot hi", v, 32'h1234_5678);
        rd(8'h7C, v); chk("R3", "snapshot lo", v, 32'h9ABC_DEF0);
        wr(8'h74, 32'h11);
        wr(8'h78, 32'h22);
        wr(8'h68, 32'hFFFF_0003);
        rd(8'h7C, v); chk("R4", "latched lo kept over load", v, 32'h9ABC_DEF0);
        rd(8'h80, v); chk("R4", "latched hi kept over load", v, 32'h1234_5678);
        rd(8'h6C, v); chk("R5", "loaded lo", v, 32'h11);
        rd(8'h70, v); chk("R5", "loaded hi", v, 32'h22);

        // R6: no-command encodings and readback
        wr(8'h74, 32'h55);
        wr(8'h68, 32'hFFFF_0002);
        rd(8'h68, v); chk("R6", "ctrl readback strobes clear", v, 32'hFFFF_0000);
        rd(8'h6C, v); chk("R6", "bits 10 loads nothing", v, 32'h11);
        rd(8'h7C, v); chk("R6", "bits 10 snaps nothing", v, 32'h9ABC_DEF0);
        wr(8'h68, 32'hFFFF_0000);
        rd(8'h6C, v); chk("R6", "bits 00 loads nothing", v, 32'h11);

        // R8 / R9: read-only addresses and preload readback
        wr(8'h6C, 32'hDEAD_0001);
        wr(8'h70, 32'hDEAD_0002);
        wr(8'h7C, 32'hBEEF_0003);
        wr(8'h80, 32'hBEEF_0004);
        rd(8'h6C, v); chk("R8", "live lo ignores write", v, 32'h11);
        rd(8'h70, v); chk("R8", "live hi ignores write", v, 32'h22);
        rd(8'h7C, v); chk("R8", "latched lo ignores write", v, 32'h9ABC_DEF0);
        rd(8'h80, v); chk("R8", "latched hi ignores write", v, 32'h1234_5678);
        rd(8'h74, v); chk("R9", "preload lo readback", v, 32'h55);
        rd(8'h78, v); chk("R9", "preload hi readback", v, 32'h22);
        rd(8'h40, v); chk("R9", "unmapped reads zero", v, 32'h0);

        // R3 / R7: snapshot on an incrementing edge, word carry
        wr(8'h74, 32'hFFFF_FFFE);
        wr(8'h78, 32'h0);
        wr(8'h68, 32'h0000_0003);
        wr(8'h68, 32'h0000_0001);
        rd(8'h7C, v); chk("R3", "pre-increment value lo", v, 32'hFFFF_FFFF);
        rd(8'h80, v); chk("R3", "pre-increment value hi", v, 32'h0);
        rd(8'h70, v); chk("R7", "carry into high word", v, 32'h1);

        // R7: full wrap
        wr(8'h78, 32'hFFFF_FFFF);
        wr(8'h68, 32'h0000_0003);
        @(posedge clk); #2 bus_addr = 8'h70;
        #1 chk("R7", "all ones before wrap", bus_rdata, 32'hFFFF_FFFF);
        @(posedge clk); #3;
        chk("R7", "hi wraps to zero", bus_rdata, 32'h0);
        bus_addr = 8'h6C;
        #1 chk("R7", "lo wraps to zero", bus_rdata, 32'h0);

        // Mixed traffic under divider 2, compared every clock
        wr(8'h68, 32'h0002_0000);
        for (int i = 0; i < 120; i++) begin
            if (i % 17 == 5) begin
                wr(8'h68, 32'h0002_0001);
            end else if (i % 29 == 11) begin
                wr(8'h74, 32'(i * 7));
                wr(8'h68, 32'h0002_0003);
            end else begin
                @(posedge clk); #2;
                case (i % 7)
                    0: bus_addr = 8'h68;
                    1: bus_addr = 8'h6C;
                    2: bus_addr = 8'h70;
                    3: bus_addr = 8'h74;
                    4: bus_addr = 8'h78;
                    5: bus_addr = 8'h7C;
                    default: bus_addr = 8'h80;
                endcase
            end
        end

        @(posedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule